// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every bus access a processor core makes and compares it against up to four programmable breakpoints. Each breakpoint has an address register and its own slot in a shared control word. The slot selects the kind of access that trips it and the size of the aligned address window it covers. When an armed breakpoint sees a matching access, the block sets a sticky hit bit in a status word and raises a one-cycle debug request toward the core's exception logic.

The same unit also handles three related events. It raises single-step traps on retired instructions while the core's trap flag is set. It suppresses instruction-fetch breakpoints while a resume flag is in force. It traps privileged register accesses while a guard bit is armed. A task-switch pulse clears every local enable and records the event in the status word.

Software reaches every register through a privileged read/write port. Accesses flagged as unprivileged are dropped.

Top module: `bkpt_match_unit`

## Requirements
- R1: Register select 0..3 addresses the breakpoint address registers, 4 the control word and 5 the status word. A privileged write updates the selected register at the clock edge. A privileged read presents the value on the read-data output in the following cycle; in any other cycle that output is zero. Accesses with the privilege input low change nothing and read as zero.
- R2: Breakpoint n takes part in matching only if control bit 2n (local enable) or control bit 2n+1 (global enable) is set.
- R3: Breakpoint n has a size code in control bits [18+4n +: 2]. Code 00 covers 1 byte, 01 covers 2 bytes and 11 covers 4 bytes. Code 10 never matches.
- R4: Breakpoint n has an access-kind code in control bits [16+4n +: 2]. Access kinds are 00 fetch, 01 read, 10 write and 11 port. Code 00 matches fetches only, 01 writes only, and 11 reads or writes. Code 10 matches port accesses only when the extension-enable input is high, and never otherwise.
- R5: The access size uses the same codes as the breakpoint size, with 10 treated as 4 bytes. A match requires the breakpoint address and the access address to be equal once the low address bits are cleared. The number of bits cleared is log2 of the larger of the two sizes.
- R6: The status word holds hit bits 0..3, a register-trap bit 13, a step bit 14 and a task bit 15. All other bits read as 1, so after reset the status output is 0xFFFF1FF0.
- R7: Hit bits are sticky, and one access may set several of them. A status write replaces the live bits with the written value. An event in the same cycle still sets its bit.
- R8: The debug request is high for exactly the one cycle after a cycle holding a breakpoint match, a step trap or a guarded register access.
- R9: On each retire strobe, a step trap is raised if the trap-flag input was high at the previous retire strobe. A newly raised flag therefore first traps on the second retire.
- R10: While the resume input is high, fetch-kind matches are suppressed. The suppression persists after the input falls and ends at the next retire strobe. Data matches are never suppressed.
- R11: While control bit 13 (guard) is set, a privileged register access is not performed. Instead it raises the debug request, sets the register-trap bit and clears the guard bit.
- R12: A task-switch pulse clears all local enable bits, keeps the global enables and sets the task status bit.
- R13: Reset, synchronous and active-high, clears all address registers, the control word, the status bits and the debug request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Bus access present this cycle |
| acc_addr_i | input | AW | Access address |
| acc_size_i | input | 2 | Access size code |
| acc_kind_i | input | 2 | Access kind: fetch, read, write, port |
| retire_i | input | 1 | Instruction retire strobe |
| step_flag_i | input | 1 | Core trap flag (single step) |
| resume_flag_i | input | 1 | Core resume flag |
| ext_en_i | input | 1 | Extension enable for port breakpoints |
| task_sw_i | input | 1 | Task-switch pulse |
| reg_en_i | input | 1 | Register port access strobe |
| reg_we_i | input | 1 | Register port write (1) or read (0) |
| reg_priv_i | input | 1 | Access is privileged |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the read |
| dbg_req_o | output | 1 | Debug exception request pulse |
| status_o | output | 32 | Status word with unused bits at 1 |

## Verification
The bench sweeps the full product of breakpoint size code, breakpoint kind code, extension enable, access kind, access size and every aligned offset around a breakpoint. This separates the window arithmetic from the kind decoding and shows that the undefined codes stay silent. A second sweep runs all 256 enable patterns against four breakpoints, which separates local from global enables and catches cross-talk between slots. Directed sequences cover step-trap latency on both edges of the trap flag, resume suppression with and without an intervening retire, a guarded access, task-switch clearing, multi-hit stickiness and the privilege filter.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_PORT  = 2'b11
  } acc_kind_e;

  localparam int REG_W      = 32;
  localparam int SEL_CTRL   = 4;
  localparam int SEL_STAT   = 5;
  localparam int CTL_GUARD  = 13;
  localparam int ST_REGTRAP = 13;
  localparam int ST_STEP    = 14;
  localparam int ST_TASK    = 15;
  localparam int FLD_BASE   = 16;
  localparam int FLD_STRIDE = 4;

  // log2 of a window size given its 2-bit code (undefined code maps to 4 bytes)
  function automatic logic [1:0] span_log2(input logic [1:0] code);
    case (code)
      2'b00:   span_log2 = 2'd0;
      2'b01:   span_log2 = 2'd1;
      default: span_log2 = 2'd2;
    endcase
  endfunction

  // status bits that hold state; every other bit reads as one
  function automatic logic [REG_W-1:0] live_mask(input int nbp);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < nbp; i++) m[i] = 1'b1;
    m[ST_REGTRAP] = 1'b1;
    m[ST_STEP]    = 1'b1;
    m[ST_TASK]    = 1'b1;
    return m;
  endfunction

  // control bits holding the local enables
  function automatic logic [REG_W-1:0] local_mask(input int nbp);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < nbp; i++) m[2*i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bp_addr,
  input  logic          enabled,
  input  logic [1:0]    kind_code,
  input  logic [1:0]    size_code,
  input  logic          ext_en,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    acc_kind,
  input  logic          fetch_block,
  output logic          hit
);
  logic [1:0]    lg_bp, lg_acc, lg;
  logic [AW-1:0] low_mask;
  logic          kind_ok, addr_ok, size_ok;

  always_comb begin
    lg_bp    = span_log2(size_code);
    lg_acc   = span_log2(acc_size);
    lg       = (lg_bp > lg_acc) ? lg_bp : lg_acc;
    low_mask = (AW'(1) << lg) - AW'(1);
    addr_ok  = ((bp_addr ^ acc_addr) & ~low_mask) == '0;
    size_ok  = (size_code != 2'b10);
    case (kind_code)
      2'b00:   kind_ok = (acc_kind == ACC_FETCH) && !fetch_block;
      2'b01:   kind_ok = (acc_kind == ACC_WRITE);
      2'b11:   kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
      default: kind_ok = ext_en && (acc_kind == ACC_PORT);
    endcase
    hit = acc_valid && enabled && size_ok && kind_ok && addr_ok;
  end

  // R3
  bad_size_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    (size_code == 2'b10) |-> !hit);

  // R10
  resume_block_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_block && acc_kind == ACC_FETCH) |-> !hit);

  // R4
  port_needs_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_PORT && !ext_en) |-> !hit);
endmodule

// File: rtl/bkpt_event.sv
module bkpt_event
  import bkpt_pkg::*;
#(
  parameter int NBP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBP-1:0]   hits,
  input  logic             retire,
  input  logic             step_flag,
  input  logic             guard_hit,
  input  logic             task_sw,
  input  logic             stat_wr,
  input  logic [REG_W-1:0] stat_wdata,
  output logic [REG_W-1:0] stat_q,
  output logic             dbg_req
);
  localparam logic [REG_W-1:0] LIVE = live_mask(NBP);

  logic             step_live;
  logic             step_trap;
  logic [REG_W-1:0] stat_nxt;

  assign step_trap = retire && step_live;

  always_comb begin
    stat_nxt = stat_wr ? (stat_wdata & LIVE) : stat_q;
    stat_nxt[NBP-1:0] = stat_nxt[NBP-1:0] | hits;
    if (step_trap) stat_nxt[ST_STEP]    = 1'b1;
    if (guard_hit) stat_nxt[ST_REGTRAP] = 1'b1;
    if (task_sw)   stat_nxt[ST_TASK]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      dbg_req   <= 1'b0;
      step_live <= 1'b0;
    end else begin
      stat_q  <= stat_nxt;
      dbg_req <= (|hits) || step_trap || guard_hit;
      if (retire) step_live <= step_flag;
    end
  end

  // R7
  hits_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((stat_q[NBP-1:0] & $past(stat_q[NBP-1:0])) == $past(stat_q[NBP-1:0])));

  // R9
  step_report_chk: assert property (@(posedge clk) disable iff (rst)
    (retire && step_live) |=> (dbg_req && stat_q[ST_STEP]));
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int NBP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_size_i,
  input  logic [1:0]    acc_kind_i,
  input  logic          retire_i,
  input  logic          step_flag_i,
  input  logic          resume_flag_i,
  input  logic          ext_en_i,
  input  logic          task_sw_i,
  input  logic          reg_en_i,
  input  logic          reg_we_i,
  input  logic          reg_priv_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          dbg_req_o,
  output logic [31:0]   status_o
);
  localparam int               SEL_W  = 3;
  localparam logic [REG_W-1:0] LIVE   = live_mask(NBP);
  localparam logic [REG_W-1:0] LOCALS = local_mask(NBP);

  logic [AW-1:0]    bp_addr_q [NBP];
  logic [REG_W-1:0] ctrl_q, ctrl_nxt, stat_raw, rd_mux, rdata_q;
  logic [NBP-1:0]   hits;
  logic             res_pend_q, fetch_block;
  logic             acc_ok, guard_hit, wr_go, rd_go, stat_wr;

  assign acc_ok      = reg_en_i && reg_priv_i;
  assign guard_hit   = acc_ok && ctrl_q[CTL_GUARD];
  assign wr_go       = acc_ok && !ctrl_q[CTL_GUARD] && reg_we_i;
  assign rd_go       = acc_ok && !ctrl_q[CTL_GUARD] && !reg_we_i;
  assign stat_wr     = wr_go && (reg_sel_i == SEL_W'(SEL_STAT));
  assign fetch_block = resume_flag_i || res_pend_q;

  // address registers and comparators, one per breakpoint
  for (genvar n = 0; n < NBP; n++) begin : g_bp
    always_ff @(posedge clk) begin
      if (rst)
        bp_addr_q[n] <= '0;
      else if (wr_go && reg_sel_i == SEL_W'(n))
        bp_addr_q[n] <= reg_wdata_i[AW-1:0];
    end

    bkpt_cmp #(.AW(AW)) u_cmp (
      .clk        (clk),
      .rst        (rst),
      .bp_addr    (bp_addr_q[n]),
      .enabled    (ctrl_q[2*n] || ctrl_q[2*n+1]),
      .kind_code  (ctrl_q[FLD_BASE+FLD_STRIDE*n +: 2]),
      .size_code  (ctrl_q[FLD_BASE+FLD_STRIDE*n+2 +: 2]),
      .ext_en     (ext_en_i),
      .acc_valid  (acc_valid_i),
      .acc_addr   (acc_addr_i),
      .acc_size   (acc_size_i),
      .acc_kind   (acc_kind_i),
      .fetch_block(fetch_block),
      .hit        (hits[n])
    );
  end

  // control word: software write, guard self-clear, task-switch local clear
  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_go && reg_sel_i == SEL_W'(SEL_CTRL)) ctrl_nxt = reg_wdata_i;
    if (guard_hit) ctrl_nxt[CTL_GUARD] = 1'b0;
    if (task_sw_i) ctrl_nxt = ctrl_nxt & ~LOCALS;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nxt;
  end

  // resume suppression lasts until the next retire
  always_ff @(posedge clk) begin
    if (rst)                res_pend_q <= 1'b0;
    else if (resume_flag_i) res_pend_q <= 1'b1;
    else if (retire_i)      res_pend_q <= 1'b0;
  end

  // read path
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NBP; i++)
      if (reg_sel_i == SEL_W'(i)) rd_mux = REG_W'(bp_addr_q[i]);
    if (reg_sel_i == SEL_W'(SEL_CTRL)) rd_mux = ctrl_q;
    if (reg_sel_i == SEL_W'(SEL_STAT)) rd_mux = stat_raw | ~LIVE;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_go) rdata_q <= rd_mux;
    else            rdata_q <= '0;
  end

  bkpt_event #(.NBP(NBP)) u_event (
    .clk       (clk),
    .rst       (rst),
    .hits      (hits),
    .retire    (retire_i),
    .step_flag (step_flag_i),
    .guard_hit (guard_hit),
    .task_sw   (task_sw_i),
    .stat_wr   (stat_wr),
    .stat_wdata(reg_wdata_i),
    .stat_q    (stat_raw),
    .dbg_req   (dbg_req_o)
  );

  assign reg_rdata_o = rdata_q;
  assign status_o    = stat_raw | ~LIVE;

  // R12
  task_clears_local_chk: assert property (@(posedge clk) disable iff (rst)
    task_sw_i |=> ((ctrl_q & LOCALS) == '0));

  // R11
  guard_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_en_i && reg_priv_i && ctrl_q[CTL_GUARD]) |=>
      (dbg_req_o && status_o[ST_REGTRAP] && !ctrl_q[CTL_GUARD]));

  // R1
  unpriv_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_en_i && !reg_priv_i && !task_sw_i) |=> (reg_rdata_o == '0 && $stable(ctrl_q)));
endmodule

// File: tb/bkpt_match_unit_bench.sv
module bkpt_match_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic [1:0]  acc_kind_i = '0;
  logic        retire_i = 1'b0, step_flag_i = 1'b0, resume_flag_i = 1'b0;
  logic        ext_en_i = 1'b0, task_sw_i = 1'b0;
  logic        reg_en_i = 1'b0, reg_we_i = 1'b0, reg_priv_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o, status_o;
  logic        dbg_req_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_match_unit u_bkpt_match_unit (
    .clk(clk), .rst(rst),
    .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i), .acc_size_i(acc_size_i),
    .acc_kind_i(acc_kind_i), .retire_i(retire_i), .step_flag_i(step_flag_i),
    .resume_flag_i(resume_flag_i), .ext_en_i(ext_en_i), .task_sw_i(task_sw_i),
    .reg_en_i(reg_en_i), .reg_we_i(reg_we_i), .reg_priv_i(reg_priv_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .dbg_req_o(dbg_req_o), .status_o(status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_acc(input bit we, input bit priv, input int sel, input logic [31:0] d);
    @(negedge clk);
    reg_en_i = 1'b1; reg_we_i = we; reg_priv_i = priv;
    reg_sel_i = 3'(sel); reg_wdata_i = d;
    @(negedge clk);
    rd = reg_rdata_o;
    reg_en_i = 1'b0; reg_we_i = 1'b0; reg_priv_i = 1'b0;
  endtask

  task automatic reg_wr(input int sel, input logic [31:0] d);
    reg_acc(1'b1, 1'b1, sel, d);
  endtask

  task automatic access(input logic [31:0] a, input int sz, input int kind);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_size_i = 2'(sz); acc_kind_i = 2'(kind);
    @(negedge clk);
    acc_valid_i = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk);
    retire_i = 1'b1;
    @(negedge clk);
    retire_i = 1'b0;
  endtask

  function automatic bit exp_hit(int sz, int kd, int ext, int ak, int asz, int addr);
    int blen, alen, w;
    bit kok;
    if (sz == 2) return 1'b0;
    blen = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    alen = (asz == 0) ? 1 : (asz == 1) ? 2 : 4;
    w = (blen > alen) ? blen : alen;
    kok = (kd == 0 && ak == 0) || (kd == 1 && ak == 2) ||
          (kd == 3 && (ak == 1 || ak == 2)) || (kd == 2 && ext == 1 && ak == 3);
    return kok && ((addr / w) == (32'h104 / w));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R13 / R6 reset state
    chk("R6 status after reset", status_o, 32'hFFFF1FF0);
    chk("R13 dbg_req after reset", {31'd0, dbg_req_o}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      reg_acc(1'b0, 1'b1, i, 0);
      chk("R13 register cleared", rd, 32'd0);
    end

    // R1 privileged access and filtering
    reg_wr(1, 32'hDEADBEE0);
    reg_acc(1'b0, 1'b1, 1, 0);
    chk("R1 address readback", rd, 32'hDEADBEE0);
    reg_acc(1'b1, 1'b0, 1, 32'h1);
    reg_acc(1'b0, 1'b1, 1, 0);
    chk("R1 unprivileged write ignored", rd, 32'hDEADBEE0);
    reg_acc(1'b0, 1'b0, 1, 0);
    chk("R1 unprivileged read is zero", rd, 32'd0);
    reg_acc(1'b0, 1'b1, 5, 0);
    chk("R1 status readable", rd, 32'hFFFF1FF0);

    // R3 R4 R5 sweep on breakpoint 0 at 0x104
    reg_wr(0, 32'h104);
    for (int sz = 0; sz < 4; sz++)
      for (int kd = 0; kd < 4; kd++) begin
        reg_wr(4, 32'h1 | (kd << 16) | (sz << 18));
        for (int ext = 0; ext < 2; ext++) begin
          ext_en_i = ext[0];
          for (int ak = 0; ak < 4; ak++)
            for (int ai = 0; ai < 3; ai++) begin
              int asz, alen;
              asz = (ai == 2) ? 3 : ai;
              alen = 1 << ai;
              for (int off = 0; off < 8; off += alen) begin
                bit e;
                e = exp_hit(sz, kd, ext, ak, asz, 32'h100 + off);
                access(32'h100 + off, asz, ak);
                chk("R3 R4 R5 match request", {31'd0, dbg_req_o}, {31'd0, e});
                chk("R5 hit bit", {31'd0, status_o[0]}, {31'd0, e});
                if (status_o[0]) reg_wr(5, 0);
              end
            end
        end
      end
    ext_en_i = 1'b0;

    // R2 enable sweep on four breakpoints
    for (int n = 0; n < 4; n++) reg_wr(n, 32'h200 + 32'h10 * n);
    for (int e = 0; e < 256; e++) begin
      reg_wr(4, e);
      for (int n = 0; n < 4; n++) begin
        bit x;
        x = ((e >> (2 * n)) & 3) != 0;
        access(32'h200 + 32'h10 * n, 0, 0);
        chk("R2 enable gating", {28'd0, status_o[3:0]}, {28'd0, 4'(x) << n});
        if (x) reg_wr(5, 0);
      end
    end

    // R7 multi-hit and stickiness, R8 pulse width
    reg_wr(0, 32'h300);
    reg_wr(1, 32'h302);
    reg_wr(4, 32'h1 | 32'h4 | (3 << 18));
    access(32'h302, 0, 0);
    chk("R7 two hits at once", {30'd0, status_o[1:0]}, 32'd3);
    chk("R8 request after hit", {31'd0, dbg_req_o}, 32'd1);
    @(negedge clk);
    chk("R8 request lasts one cycle", {31'd0, dbg_req_o}, 32'd0);
    access(32'h310, 0, 0);
    chk("R7 sticky without hit", {30'd0, status_o[1:0]}, 32'd3);
    chk("R8 no request without event", {31'd0, dbg_req_o}, 32'd0);
    reg_wr(5, 32'h2);
    chk("R7 write replaces", {30'd0, status_o[1:0]}, 32'd2);
    reg_wr(5, 32'h0);
    chk("R7 write clears", status_o, 32'hFFFF1FF0);

    // R9 single step latency
    reg_wr(4, 32'h0);
    @(negedge clk); step_flag_i = 1'b1;
    retire();
    chk("R9 first retire after flag set", {31'd0, dbg_req_o}, 32'd0);
    retire();
    chk("R9 second retire traps", {31'd0, dbg_req_o}, 32'd1);
    chk("R9 step bit", {31'd0, status_o[14]}, 32'd1);
    reg_wr(5, 0);
    @(negedge clk); step_flag_i = 1'b0;
    retire();
    chk("R9 retire after flag clear still traps", {31'd0, dbg_req_o}, 32'd1);
    retire();
    chk("R9 no trap once flag seen low", {31'd0, dbg_req_o}, 32'd0);
    reg_wr(5, 0);

    // R10 resume suppression
    reg_wr(0, 32'h400);
    reg_wr(4, 32'h1);
    @(negedge clk); resume_flag_i = 1'b1;
    access(32'h400, 0, 0);
    chk("R10 fetch suppressed", {31'd0, dbg_req_o}, 32'd0);
    @(negedge clk); resume_flag_i = 1'b0;
    access(32'h400, 0, 0);
    chk("R10 suppression held until retire", {31'd0, dbg_req_o}, 32'd0);
    retire();
    access(32'h400, 0, 0);
    chk("R10 fetch matches after retire", {31'd0, dbg_req_o}, 32'd1);
    reg_wr(5, 0);
    reg_wr(4, 32'h1 | (3 << 16));
    @(negedge clk); resume_flag_i = 1'b1;
    access(32'h400, 0, 1);
    chk("R10 data match not suppressed", {31'd0, dbg_req_o}, 32'd1);
    @(negedge clk); resume_flag_i = 1'b0;
    retire();
    reg_wr(5, 0);

    // R11 guard
    reg_wr(4, (32'h1 << 13) | 32'h2);
    reg_acc(1'b0, 1'b1, 4, 0);
    chk("R11 guarded read blocked", rd, 32'd0);
    chk("R11 guarded access requests", {31'd0, dbg_req_o}, 32'd1);
    chk("R11 register-trap bit", {31'd0, status_o[13]}, 32'd1);
    reg_acc(1'b0, 1'b1, 4, 0);
    chk("R11 guard cleared, read performed", rd, 32'h2);
    reg_wr(5, 0);

    // R12 task switch
    reg_wr(4, 32'hFF);
    @(negedge clk); task_sw_i = 1'b1;
    @(negedge clk); task_sw_i = 1'b0;
    chk("R12 task bit", {31'd0, status_o[15]}, 32'd1);
    reg_acc(1'b0, 1'b1, 4, 0);
    chk("R12 locals cleared, globals kept", rd, 32'hAA);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule